// File: doc/BRIEF.md
# Ones' Complement Adder with End-Around Carry

This block adds two N-bit ones' complement codes (N defaults to 16). A positive value is held as its own binary pattern. A negative value x is held as (2^N - 1) + x, so its top bit is set. The all-ones code is a second zero, negative zero.

A plain binary adder forms the raw sum. Any carry out of the top bit is not thrown away: it comes back in at bit zero as an increment. The result is therefore arithmetic modulo 2^N - 1. A subtract control bit-inverts the second operand before the add, which negates it in this number system.

The outputs are:
- the result code;
- a signed-overflow flag;
- a flag that marks a negative-zero result.

A parameter chooses between two variants. One is purely combinational. The other puts one register stage on the outputs, and that register clears to zero on reset.

Top module: `oc_eac_adder`

## Requirements
- R1: With sub_i low and no carry out of the top bit, sum_o equals the plain binary sum a_i + b_i (for example, 0x0003 + 0x0004 gives 0x0007).
- R2: When the binary sum carries out of bit N-1, that carry is added back at bit 0 (for example, 0xFFFE + 0x0003 gives 0x0002, and 0xFFFF + 0xFFFF gives 0xFFFF).
- R3: Two operands that are bitwise inverses of each other (opposite signs, true sum zero) give the all-ones code 0xFFFF.
- R4: Negative zero (0xFFFF) plus negative zero gives 0xFFFF. Negative zero plus positive zero (0x0000), in either order, also gives 0xFFFF.
- R5: sum_o is 0x0000 only when both effective operands are 0x0000.
- R6: ovf_o is 1 exactly when the two effective operands share a top bit and sum_o has the other top bit. In value terms, this is when the true sum lies outside ±(2^(N-1) - 1).
- R7: negzero_o is 1 exactly when sum_o is all ones.
- R8: With sub_i high, the block computes a_i + (~b_i) using the same end-around rule, so it yields a_i - b_i (for example, 0x0005 - 0x0003 gives 0x0002).
- R9: For all inputs, sum_o is congruent to a_i + b_eff modulo 2^N - 1, where b_eff is b_i or ~b_i according to sub_i.
- R10: With REG_OUT=1, the outputs show the result for the inputs present at the previous rising clock edge. While rst_n is low, all outputs are 0.
- R11: With REG_OUT=0, the outputs follow the inputs in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT=1 |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| sub_i | input | 1 | 1 = subtract (invert b_i before the add) |
| a_i | input | N | First operand code |
| b_i | input | N | Second operand code |
| sum_o | output | N | Result code |
| ovf_o | output | 1 | Signed overflow |
| negzero_o | output | 1 | Result is negative zero (all ones) |

## Verification
The hardest outcomes to reach are the zero cases. An opposite-sign pair sums to zero only when one operand is the exact bitwise inverse of the other. Positive zero as a result needs both operands to be 0x0000. Uniform random inputs almost never produce either.

The stimulus therefore forces both zeros in directed cases, including with subtract mode, where b_i equal to a_i produces the inverse pair. It also biases a share of the random draws toward inverse pairs, the two zero codes and the extreme magnitudes that overflow.

// File: rtl/oc_eac_pkg.sv
package oc_eac_pkg;
   typedef struct packed {
      logic ovf;
      logic negzero;
   } oc_flags_t;

   function automatic logic same_sign(input logic sa, input logic sb);
      return ~(sa ^ sb);
   endfunction
endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
   parameter int N = 16
) (
   input  logic         sub_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] b_eff_o
);
   // Negation in ones' complement is a bitwise inversion.
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign b_eff_o[i] = b_i[i] ^ sub_i;
   end
endmodule

// File: rtl/oc_eac_core.sv
module oc_eac_core #(
   parameter int N = 16
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] sum_o
);
   localparam int W = N + 1;

   logic [W-1:0] raw;
   logic         cout;

   always_comb begin
      raw  = {1'b0, a_i} + {1'b0, b_i};
      cout = raw[N];
   end

   // When cout is set the low part is at most 2^N - 2,
   // so the increment cannot carry out a second time.
   assign sum_o = raw[N-1:0] + {{(N-1){1'b0}}, cout};
endmodule

// File: rtl/oc_flag_gen.sv
module oc_flag_gen
   import oc_eac_pkg::*;
#(
   parameter int N = 16
) (
   input  logic         sign_a_i,
   input  logic         sign_b_i,
   input  logic [N-1:0] sum_i,
   output oc_flags_t    flags_o
);
   always_comb begin
      flags_o.ovf     = same_sign(sign_a_i, sign_b_i) & (sum_i[N-1] ^ sign_a_i);
      flags_o.negzero = &sum_i;
   end
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder
   import oc_eac_pkg::*;
#(
   parameter int N       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sub_i,
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] sum_o,
   output logic         ovf_o,
   output logic         negzero_o
);
   if (N < 2) begin : g_bad_width
      $error("oc_eac_adder: N must be at least 2");
   end

   logic [N-1:0] b_eff;
   logic [N-1:0] sum_c;
   oc_flags_t    flags_c;

   oc_operand_prep #(.N(N)) u_prep (
      .sub_i  (sub_i),
      .b_i    (b_i),
      .b_eff_o(b_eff)
   );

   oc_eac_core #(.N(N)) u_core (
      .a_i  (a_i),
      .b_i  (b_eff),
      .sum_o(sum_c)
   );

   oc_flag_gen #(.N(N)) u_flags (
      .sign_a_i(a_i[N-1]),
      .sign_b_i(b_eff[N-1]),
      .sum_i   (sum_c),
      .flags_o (flags_c)
   );

   if (REG_OUT) begin : g_reg
      logic [N-1:0] sum_q;
      oc_flags_t    flags_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_q   <= '0;
            flags_q <= '0;
         end else begin
            sum_q   <= sum_c;
            flags_q <= flags_c;
         end
      end
      assign sum_o     = sum_q;
      assign ovf_o     = flags_q.ovf;
      assign negzero_o = flags_q.negzero;
   end else begin : g_comb
      assign sum_o     = sum_c;
      assign ovf_o     = flags_c.ovf;
      assign negzero_o = flags_c.negzero;
   end
endmodule

// File: rtl/oc_eac_adder_chk.sv
module oc_eac_adder_chk #(
   parameter int N       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sub_i,
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic [N-1:0] sum_o,
   input logic         ovf_o,
   input logic         negzero_o
);
   localparam logic [N:0] MODV = {1'b0, {N{1'b1}}};

   logic [N-1:0] ca, cb;
   logic         seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   if (REG_OUT) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ca <= '0;
            cb <= '0;
         end else begin
            ca <= a_i;
            cb <= sub_i ? ~b_i : b_i;
         end
      end
   end else begin : g_pass
      assign ca = a_i;
      assign cb = sub_i ? ~b_i : b_i;
   end

   // R7
   negzero_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      negzero_o == (sum_o == {N{1'b1}}));

   // R5
   poszero_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (sum_o == '0) |-> (ca == '0 && cb == '0));

   // R3
   inverse_pair_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (ca == ~cb) |-> (sum_o == {N{1'b1}}));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (ca[N-1] != cb[N-1]) |-> !ovf_o);

   // R9
   modulo_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (({1'b0, sum_o}) % MODV) == (({1'b0, ca} + {1'b0, cb}) % MODV));
endmodule

bind oc_eac_adder oc_eac_adder_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sub_i    (sub_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .sum_o    (sum_o),
   .ovf_o    (ovf_o),
   .negzero_o(negzero_o)
);

// File: tb/oc_eac_adder_bench.sv
module oc_eac_adder_bench;
   localparam int N   = 16;
   localparam int CLK = 10;
   localparam longint MODV = (64'd1 << N) - 1;
   localparam longint LIM  = (64'd1 << (N - 1)) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sub_i = 1'b0;
   logic [N-1:0] a_i = '0, b_i = '0;
   logic [N-1:0] sum_r, sum_c;
   logic         ovf_r, ovf_c, nz_r, nz_c;

   int checks = 0;
   int failures = 0;

   always #(CLK/2) clk = ~clk;

   oc_eac_adder #(.N(N), .REG_OUT(1'b1)) u_oc_eac_adder (
      .clk(clk), .rst_n(rst_n), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
      .sum_o(sum_r), .ovf_o(ovf_r), .negzero_o(nz_r));

   oc_eac_adder #(.N(N), .REG_OUT(1'b0)) u_comb (
      .clk(clk), .rst_n(rst_n), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
      .sum_o(sum_c), .ovf_o(ovf_c), .negzero_o(nz_c));

   function automatic longint decode(input logic [N-1:0] c);
      return c[N-1] ? longint'(c) - MODV : longint'(c);
   endfunction

   // Expected {ovf, negzero, sum} from modular arithmetic on values.
   function automatic logic [N+1:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                          input logic sub);
      logic [N-1:0] be;
      longint r, tv;
      logic [N-1:0] s;
      logic ov;
      be = sub ? ~b : b;
      r  = (longint'(a) + longint'(be)) % MODV;
      if (r == 0) s = (a == '0 && be == '0) ? '0 : {N{1'b1}};
      else        s = r[N-1:0];
      tv = decode(a) + decode(be);
      ov = (tv > LIM) || (tv < -LIM);
      return {ov, (s == {N{1'b1}}), s};
   endfunction

   task automatic check(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s got=0x%0h exp=0x%0h", tag, what, got, exp);
      end
   endtask

   task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input logic sub,
                        input string tag);
      logic [N+1:0] e;
      e = model(a, b, sub);
      @(negedge clk);
      a_i = a; b_i = b; sub_i = sub;
      #1;
      // R11: combinational variant settles in the same cycle
      check({tag, "/R11"}, "comb sum", sum_c, e[N-1:0]);
      check({tag, "/R11"}, "comb ovf", ovf_c, e[N+1]);
      check({tag, "/R11"}, "comb negzero", nz_c, e[N]);
      @(negedge clk);
      // R10: registered variant shows it after one rising edge
      check({tag, "/R10"}, "reg sum", sum_r, e[N-1:0]);
      check({tag, "/R10"}, "reg ovf", ovf_r, e[N+1]);
      check({tag, "/R10"}, "reg negzero", nz_r, e[N]);
   endtask

   initial begin
      #(CLK * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [N-1:0] ra, rb;
      a_i = 16'h1234; b_i = 16'h4321;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "reset sum", sum_r, 0);
      check("R10", "reset ovf", ovf_r, 0);
      check("R10", "reset negzero", nz_r, 0);
      rst_n = 1'b1;

      apply(16'h0003, 16'h0004, 1'b0, "R1");
      apply(16'h1000, 16'h0234, 1'b0, "R1");
      apply(16'hFFFE, 16'h0003, 1'b0, "R2");
      apply(16'hFFFF, 16'hFFFF, 1'b0, "R2");
      apply(16'hFFFC, 16'hFFFA, 1'b0, "R2");
      apply(16'h0005, 16'hFFFA, 1'b0, "R3");
      apply(16'h7FFF, 16'h8000, 1'b0, "R3");
      apply(16'hFFFF, 16'hFFFF, 1'b0, "R4");
      apply(16'hFFFF, 16'h0000, 1'b0, "R4");
      apply(16'h0000, 16'hFFFF, 1'b0, "R4");
      apply(16'h0000, 16'h0000, 1'b0, "R5");
      apply(16'h0000, 16'hFFFF, 1'b1, "R5");
      apply(16'h7FFF, 16'h0001, 1'b0, "R6");
      apply(16'h8000, 16'hFFFE, 1'b0, "R6");
      apply(16'h4000, 16'h4000, 1'b0, "R6");
      apply(16'h0005, 16'h0003, 1'b1, "R8");
      apply(16'h1234, 16'h1234, 1'b1, "R8");
      apply(16'h0003, 16'h0005, 1'b1, "R8");
      apply(16'h7FFF, 16'hFFFE, 1'b1, "R8");

      void'($urandom(32'd2024));
      for (int i = 0; i < 3000; i++) begin
         ra = N'($urandom);
         rb = N'($urandom);
         case ($urandom % 8)
            0: rb = ~ra;
            1: ra = ($urandom % 2) ? '0 : {N{1'b1}};
            2: rb = ($urandom % 2) ? '0 : {N{1'b1}};
            3: begin ra[N-2:0] = {(N-1){~ra[N-1]}}; rb[N-1] = ra[N-1]; end
            default: ;
         endcase
         apply(ra, rb, 1'($urandom), "R9");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule